// File: doc/BRIEF.md
# LIN Transmit Guard and Wakeup Detector

This block is the digital control layer that sits between a LIN protocol controller, the analog bus comparator and the driver stage of a LIN transceiver. It decides when the bus driver may pull the line dominant, shapes the level presented on the RxD pin, and recognises remote wakeups from the bus. A mode controller elsewhere on the chip selects the transceiver sub-mode: off, wakeup-listen or active. The host's EN level is also visible here, so that the driver can be cut the moment EN drops.

The transmit path only starts a dominant phase after TxD is seen falling while transmission is allowed. If TxD then stays low for too long, a timeout releases the driver. The driver stays released until TxD returns high and falls again. The receive path first synchronises the comparator output and then debounces it. In active mode the filtered level goes to RxD. The wakeup detector measures the length of each filtered dominant phase with a saturating counter. A long enough phase that ends while the transceiver is in wakeup-listen mode latches a wakeup. The latched wakeup pulls RxD low until the controller is back in active mode with EN high.

The transmit guard has four states. TX_BLOCK waits for TxD high. TX_ARMED waits for a falling edge. TX_DRIVE drives the bus dominant and counts. TX_EXPIRED holds the driver released after a timeout. Its transitions are:
- arm: TX_BLOCK to TX_ARMED when TxD is high.
- start: TX_ARMED to TX_DRIVE when TxD is low.
- end: TX_DRIVE to TX_ARMED when TxD is high.
- timeout: TX_DRIVE to TX_EXPIRED after TO_TICKS cycles.
- recover: TX_EXPIRED to TX_ARMED when TxD is high.
- block: any state to TX_BLOCK whenever the mode is not active or EN is low.

The wakeup detector has three states: WK_IDLE, WK_MEASURE and WK_LATCHED. Its transitions are:
- measure: WK_IDLE to WK_MEASURE when the filtered bus is dominant.
- discard: WK_MEASURE to WK_IDLE on a recessive bus after a short phase, or after any phase that ends in active mode.
- latch: WK_MEASURE to WK_LATCHED on a recessive bus after at least WAKE_TICKS dominant cycles, with the mode at wakeup-listen.
- clear: WK_LATCHED to WK_IDLE when the mode is active and EN is high.
- off: any state to WK_IDLE in off mode.

Top module: `lin_txwake_ctrl`

## Requirements
- R1: In off mode (mode_i 2'b00, or the unused code 2'b11) drv_dom_o is 0 and rxd_o is 1 whatever TxD and the bus do. After reset drv_dom_o is 0, rxd_o is 1 and wake_o is 0.
- R2: Transmission is only allowed in active mode (mode_i 2'b10) with en_i high. If TxD is already low when transmission becomes allowed, the bus is not driven until TxD has been seen high and then low.
- R3: From the armed state, drv_dom_o goes to 1 in the cycle after TxD is sampled low. It goes back to 0 in the cycle after TxD is sampled high.
- R4: drv_dom_o stays 1 for at most TO_TICKS consecutive cycles. After the timeout it stays 0 until TxD has returned high and fallen again.
- R5: drv_dom_o drops to 0 in the same cycle as en_i falls, with no clock edge needed. Raising en_i again while TxD is still low does not restart the drive.
- R6: rx_cmp_i is 1 for a recessive bus and 0 for a dominant bus. It passes through SYNC_STAGES flops and a debouncer that needs FILT_LEN equal samples in a row. In active mode rxd_o shows the filtered level, and pulses shorter than FILT_LEN cycles are ignored.
- R7: In wakeup-listen mode (mode_i 2'b01) the driver stays off. A filtered dominant phase of at least WAKE_TICKS cycles, followed by recessive, sets wake_o and pulls rxd_o to 0. A shorter phase has no effect.
- R8: A dominant phase that starts in active mode and ends in wakeup-listen mode is a valid wakeup. A phase that both starts and ends in active mode is not.
- R9: A latched wakeup keeps wake_o at 1 and rxd_o at 0, even when en_i is high in wakeup-listen mode. It clears one cycle after the mode is active with en_i high.
- R10: The dominant-length counter saturates. A dominant phase many times longer than the counter range still gives a valid wakeup.
- R11: Off mode forces rxd_o to 1 at once, clears a latched wakeup and detects no new wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Sub-mode: 00 off, 01 wakeup-listen, 10 active, 11 treated as off |
| en_i | input | 1 | Host enable level |
| txd_i | input | 1 | Host transmit data, low means dominant |
| rx_cmp_i | input | 1 | Bus comparator output, 1 recessive, 0 dominant |
| drv_dom_o | output | 1 | Driver request, 1 pulls the bus dominant |
| rxd_o | output | 1 | Level for the RxD pin |
| wake_o | output | 1 | Latched wakeup flag for the mode controller |

## Verification
The driver cut-off and the wakeup measurement can act in the same cycle. This happens when the host is transmitting a dominant phase and drops EN just as the controller moves the transceiver to wakeup-listen. The bench provokes this by keeping TxD and the bus dominant in active mode for longer than the wakeup length. It then lowers EN and switches the mode on the same clock phase. It checks that drv_dom_o falls at once, with no clock edge. It then releases the bus and checks that the one dominant phase, which started in active mode, is counted as a wakeup. A matching run that ends while still in active mode must not latch a wakeup.

// File: rtl/lin_txwake_pkg.sv
package lin_txwake_pkg;

    typedef enum logic [1:0] {
        LM_OFF    = 2'b00,
        LM_WAKE   = 2'b01,
        LM_ACTIVE = 2'b10,
        LM_RSVD   = 2'b11
    } lin_mode_e;

    typedef enum logic [1:0] {
        TX_BLOCK,
        TX_ARMED,
        TX_DRIVE,
        TX_EXPIRED
    } tx_state_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_MEASURE,
        WK_LATCHED
    } wk_state_e;

    function automatic logic mode_is_off(input logic [1:0] m);
        return !((m == LM_WAKE) || (m == LM_ACTIVE));
    endfunction

endpackage

// File: rtl/lin_rx_filter.sv
module lin_rx_filter
    import lin_txwake_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_raw_i,
    output logic bus_dom_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic                   level_q;   // 1 = recessive
    logic [CW-1:0]          agree_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rx_raw_i;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw_i};
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    // Debounce: adopt a new level after FILT_LEN differing samples in a row.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b1;
            agree_q <= '0;
        end else if (synced != level_q) begin
            if (agree_q == CNT_LAST) begin
                level_q <= synced;
                agree_q <= '0;
            end else begin
                agree_q <= agree_q + 1'b1;
            end
        end else begin
            agree_q <= '0;
        end
    end

    assign bus_dom_o = ~level_q;

endmodule

// File: rtl/lin_tx_guard.sv
module lin_tx_guard
    import lin_txwake_pkg::*;
#(
    parameter int TO_TICKS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       txd_i,
    output logic       drv_dom_o
);
    localparam int TW = $clog2(TO_TICKS + 1);
    localparam logic [TW-1:0] TO_LAST = TW'(TO_TICKS - 1);

    tx_state_e       state_q, state_d;
    logic [TW-1:0]   hold_q;
    logic            tx_allowed;

    assign tx_allowed = (mode_i == LM_ACTIVE) && en_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!tx_allowed) begin
            state_d = TX_BLOCK;
        end else begin
            unique case (state_q)
                TX_BLOCK:   if (txd_i)  state_d = TX_ARMED;
                TX_ARMED:   if (!txd_i) state_d = TX_DRIVE;
                TX_DRIVE: begin
                    if (txd_i)                  state_d = TX_ARMED;
                    else if (hold_q == TO_LAST) state_d = TX_EXPIRED;
                end
                TX_EXPIRED: if (txd_i)  state_d = TX_ARMED;
                default:                state_d = TX_BLOCK;
            endcase
        end
    end

    // State register and dominant-hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_BLOCK;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == TX_DRIVE) && (state_d == TX_DRIVE))
                hold_q <= hold_q + 1'b1;
            else
                hold_q <= '0;
        end
    end

    // Outputs: EN gates the request combinationally
    always_comb begin
        drv_dom_o = (state_q == TX_DRIVE) && tx_allowed;
    end

endmodule

// File: rtl/lin_wake_det.sv
module lin_wake_det
    import lin_txwake_pkg::*;
#(
    parameter int WAKE_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       bus_dom_i,
    output logic       wake_o,
    output logic       rxd_o
);
    localparam int WW = $clog2(WAKE_TICKS + 1);
    localparam logic [WW-1:0] WAKE_MIN = WW'(WAKE_TICKS);

    wk_state_e     state_q, state_d;
    logic [WW-1:0] len_q;
    logic          off_now;
    logic          clear_req;

    assign off_now   = mode_is_off(mode_i);
    assign clear_req = (mode_i == LM_ACTIVE) && en_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (off_now) begin
            state_d = WK_IDLE;
        end else begin
            unique case (state_q)
                WK_IDLE:    if (bus_dom_i) state_d = WK_MEASURE;
                WK_MEASURE: begin
                    if (!bus_dom_i)
                        state_d = ((len_q >= WAKE_MIN) && (mode_i == LM_WAKE))
                                  ? WK_LATCHED : WK_IDLE;
                end
                WK_LATCHED: if (clear_req) state_d = WK_IDLE;
                default:    state_d = WK_IDLE;
            endcase
        end
    end

    // State register and saturating length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == WK_MEASURE) begin
                if (state_q != WK_MEASURE) len_q <= WW'(1);
                else if (len_q != WAKE_MIN) len_q <= len_q + 1'b1;
            end else begin
                len_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        wake_o = (state_q == WK_LATCHED);
        if (off_now)                  rxd_o = 1'b1;
        else if (state_q == WK_LATCHED) rxd_o = 1'b0;
        else if (mode_i == LM_ACTIVE) rxd_o = ~bus_dom_i;
        else                          rxd_o = 1'b1;
    end

endmodule

// File: rtl/lin_txwake_ctrl.sv
module lin_txwake_ctrl
    import lin_txwake_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int WAKE_TICKS  = 20,
    parameter int TO_TICKS    = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       rx_cmp_i,
    output logic       drv_dom_o,
    output logic       rxd_o,
    output logic       wake_o
);
    logic bus_dom;

    lin_rx_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_raw_i  (rx_cmp_i),
        .bus_dom_o (bus_dom)
    );

    lin_tx_guard #(
        .TO_TICKS (TO_TICKS)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .en_i      (en_i),
        .txd_i     (txd_i),
        .drv_dom_o (drv_dom_o)
    );

    lin_wake_det #(
        .WAKE_TICKS (WAKE_TICKS)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .en_i      (en_i),
        .bus_dom_i (bus_dom),
        .wake_o    (wake_o),
        .rxd_o     (rxd_o)
    );

endmodule

// File: rtl/lin_txwake_chk.sv
module lin_txwake_chk
    import lin_txwake_pkg::*;
#(
    parameter int TO_TICKS = 50
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       en_i,
    input logic       txd_i,
    input logic       drv_dom_o,
    input logic       rxd_o,
    input logic       wake_o
);
    localparam int RW = $clog2(TO_TICKS + 2);
    localparam logic [RW-1:0] RUN_MAX = RW'(TO_TICKS + 1);

    logic          is_off;
    logic [RW-1:0] run_q;

    assign is_off = mode_is_off(mode_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run_q <= '0;
        else if (!drv_dom_o)            run_q <= '0;
        else if (run_q != RUN_MAX)      run_q <= run_q + 1'b1;
    end

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_off |-> (!drv_dom_o && rxd_o));

    // R11
    off_nowake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_off) && is_off) |-> !wake_o);

    // R5
    en_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !drv_dom_o);

    // R7
    wake_mode_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == LM_WAKE) |-> !drv_dom_o);

    // R3
    tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_dom_o) |-> ($past(txd_i) == 1'b0));

    // R4
    tx_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom_o |-> (run_q < RW'(TO_TICKS)));

    // R8
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> ($past(mode_i) == LM_WAKE));

    // R9
    wake_rxd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !is_off) |-> !rxd_o);

endmodule

bind lin_txwake_ctrl lin_txwake_chk #(.TO_TICKS(TO_TICKS)) u_chk (.*);

// File: tb/tb_lin_txwake_ctrl.sv
`timescale 1ns/1ps
module tb_lin_txwake_ctrl;
    localparam int WK = 20;
    localparam int TO = 50;
    localparam logic [1:0] M_OFF = 2'b00, M_WAKE = 2'b01, M_ACT = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_i;
    logic       en_i, txd_i, rx_cmp_i;
    logic       drv_dom_o, rxd_o, wake_o;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    lin_txwake_ctrl #(.SYNC_STAGES(2), .FILT_LEN(3), .WAKE_TICKS(WK), .TO_TICKS(TO)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(en_i), .txd_i(txd_i),
        .rx_cmp_i(rx_cmp_i), .drv_dom_o(drv_dom_o), .rxd_o(rxd_o), .wake_o(wake_o));

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_off_ignore();
        mode_i = M_OFF; en_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            txd_i = i[0]; rx_cmp_i = 1'b0;
            tick(3);
            check("R1 off drv", drv_dom_o, 1'b0);
            check("R1 off rxd", rxd_o, 1'b1);
        end
        tick(30);
        rx_cmp_i = 1'b1; txd_i = 1'b1;
        tick(10);
        check("R11 off no wake", wake_o, 1'b0);
    endtask

    task automatic t_tx_basic();
        mode_i = M_ACT; en_i = 1'b1; txd_i = 1'b1;
        tick(2);
        txd_i = 1'b0; tick(1);
        check("R3 drive on falling edge", drv_dom_o, 1'b1);
        rx_cmp_i = 1'b0; tick(8);
        check("R6 rxd follows dominant", rxd_o, 1'b0);
        txd_i = 1'b1; tick(1);
        check("R3 release on rising", drv_dom_o, 1'b0);
        rx_cmp_i = 1'b1; tick(8);
        check("R6 rxd follows recessive", rxd_o, 1'b1);
    endtask

    task automatic t_glitch();
        rx_cmp_i = 1'b0; tick(2);
        rx_cmp_i = 1'b1; tick(8);
        check("R6 short glitch filtered", rxd_o, 1'b1);
    endtask

    task automatic t_enter_low();
        mode_i = M_WAKE; en_i = 1'b0; txd_i = 1'b0; tick(2);
        mode_i = M_ACT; en_i = 1'b1; tick(10);
        check("R2 enter active with TxD low", drv_dom_o, 1'b0);
        txd_i = 1'b1; tick(2);
        check("R2 TxD high no drive", drv_dom_o, 1'b0);
        txd_i = 1'b0; tick(1);
        check("R2 fresh falling edge drives", drv_dom_o, 1'b1);
        txd_i = 1'b1; tick(1);
    endtask

    task automatic t_timeout();
        txd_i = 1'b0; tick(TO);
        check("R4 still driving at limit", drv_dom_o, 1'b1);
        tick(1);
        check("R4 released after timeout", drv_dom_o, 1'b0);
        tick(20);
        check("R4 stays released", drv_dom_o, 1'b0);
        txd_i = 1'b1; tick(2);
        txd_i = 1'b0; tick(1);
        check("R4 restart after TxD high", drv_dom_o, 1'b1);
        txd_i = 1'b1; tick(1);
    endtask

    task automatic t_en_cut();
        txd_i = 1'b0; tick(1);
        check("R5 driving before EN drop", drv_dom_o, 1'b1);
        en_i = 1'b0; #1;
        check("R5 same-cycle cut", drv_dom_o, 1'b0);
        tick(1);
        en_i = 1'b1; tick(3);
        check("R5 no restart with TxD low", drv_dom_o, 1'b0);
        txd_i = 1'b1; tick(1);
    endtask

    task automatic t_wake_basic();
        mode_i = M_WAKE; en_i = 1'b0; txd_i = 1'b0;
        rx_cmp_i = 1'b0; tick(12);
        check("R7 driver off in listen mode", drv_dom_o, 1'b0);
        rx_cmp_i = 1'b1; tick(10);
        check("R7 short dominant no wake", wake_o, 1'b0);
        check("R7 short dominant rxd", rxd_o, 1'b1);
        rx_cmp_i = 1'b0; tick(WK + 5);
        rx_cmp_i = 1'b1; tick(10);
        check("R7 long dominant wakes", wake_o, 1'b1);
        check("R7 rxd low on wake", rxd_o, 1'b0);
        txd_i = 1'b1;
    endtask

    task automatic t_latch_clear();
        en_i = 1'b1; tick(5);
        check("R9 held with EN high in listen", wake_o, 1'b1);
        check("R9 rxd held low", rxd_o, 1'b0);
        mode_i = M_ACT; tick(2);
        check("R9 cleared in active with EN", wake_o, 1'b0);
        check("R9 rxd back to bus", rxd_o, 1'b1);
    endtask

    task automatic t_cross();
        mode_i = M_ACT; en_i = 1'b1; txd_i = 1'b1; tick(2);
        txd_i = 1'b0; rx_cmp_i = 1'b0; tick(25);
        check("R3 own dominant active", drv_dom_o, 1'b1);
        mode_i = M_WAKE; en_i = 1'b0; #1;
        check("R5 cut on mode change", drv_dom_o, 1'b0);
        tick(5);
        rx_cmp_i = 1'b1; tick(10);
        check("R8 cross-mode wake", wake_o, 1'b1);
        check("R8 cross-mode rxd", rxd_o, 1'b0);
        txd_i = 1'b1; mode_i = M_ACT; en_i = 1'b1; tick(2);
        check("R9 clear after cross", wake_o, 1'b0);
        rx_cmp_i = 1'b0; tick(30);
        rx_cmp_i = 1'b1; tick(10);
        check("R8 active-only phase no wake", wake_o, 1'b0);
    endtask

    task automatic t_saturate();
        mode_i = M_WAKE; en_i = 1'b0;
        rx_cmp_i = 1'b0; tick(100);
        rx_cmp_i = 1'b1; tick(10);
        check("R10 saturated count wakes", wake_o, 1'b1);
    endtask

    task automatic t_off_clear();
        mode_i = M_OFF; #1;
        check("R11 rxd high at once", rxd_o, 1'b1);
        tick(2);
        check("R11 off clears wake", wake_o, 1'b0);
        rx_cmp_i = 1'b0; tick(30);
        rx_cmp_i = 1'b1; tick(10);
        mode_i = M_WAKE; tick(2);
        check("R11 no detection in off", wake_o, 1'b0);
        check("R11 rxd high after", rxd_o, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; mode_i = M_OFF; en_i = 1'b0; txd_i = 1'b1; rx_cmp_i = 1'b1;
        tick(3);
        check("R1 reset drv", drv_dom_o, 1'b0);
        check("R1 reset rxd", rxd_o, 1'b1);
        check("R1 reset wake", wake_o, 1'b0);
        rst_n = 1'b1;
        tick(2);
        t_off_ignore();
        t_tx_basic();
        t_glitch();
        t_enter_low();
        t_timeout();
        t_en_cut();
        t_wake_basic();
        t_latch_clear();
        t_cross();
        t_saturate();
        t_off_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule